// File: doc/BRIEF.md
# Bus Lock and Request-Grant Arbiter

This block keeps the memory bus in the hands of the local processor while a prefixed instruction runs. A read-modify-write, such as swapping a register with a memory word, then reaches memory as back-to-back bus cycles, and no other master can slip a cycle in between. The decoder sends a one-clock pulse when it sees the lock prefix. The bus sequencer sends a one-clock pulse when the last bus cycle of the instruction after the prefix finishes. From these two pulses the block drives an active-low lock output.

The block also serves one request/grant channel for an outside master. If a request comes in while the bus is unlocked, it is granted at the next bus-cycle boundary, which an idle input marks. If a request comes in while the bus is locked, it is held and granted once the lock is over. A grant stays asserted until the outside master sends a release pulse. No new lock can begin while a grant is outstanding. All inputs are assumed synchronous to the clock.

Top module: `bus_lock_arbiter`

## Requirements
- R1: Synchronous active-low reset drives lock_n high and grant low and discards any held request. After reset, a cycle with bus_idle high produces no grant.
- R2: When lock_prefix is high at a clock edge while lock_n is high and grant is low, lock_n is low after that edge.
- R3: Once low, lock_n stays low at every edge where last_cycle_done is low. It returns high after the first edge where last_cycle_done is high.
- R4: A request that arrives while lock_n is low is held. grant stays low for as long as lock_n is low.
- R5: A held request is granted after the first edge where bus_idle is high and the lock is free. The lock is free when lock_n is already high, or when last_cycle_done is high at that same edge.
- R6: A request that arrives while the bus is unlocked is granted after the first edge where bus_idle is high. That edge may be the one at which the request arrives.
- R7: grant stays high at every edge where release is low. It goes low after the first edge where release is high.
- R8: lock_prefix is ignored while grant is high, so lock_n stays high.
- R9: If lock_prefix arrives at the same edge where a request would otherwise be granted, the lock wins. The request stays held and is granted after the lock ends, under R5.
- R10: A request pulse that arrives while grant is already high is ignored. It produces no second grant after release.
- R11: A last_cycle_done pulse while the bus is unlocked has no effect. lock_n stays high and grant stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_prefix | input | 1 | One-clock pulse: lock prefix decoded |
| last_cycle_done | input | 1 | One-clock pulse: final bus cycle of the locked instruction ended |
| bus_idle | input | 1 | High on a bus-cycle boundary where the bus may be handed over |
| rq_req | input | 1 | One-clock request pulse from the outside master |
| rq_release | input | 1 | One-clock pulse: outside master hands the bus back |
| lock_n | output | 1 | Active-low bus lock |
| grant | output | 1 | Bus granted to the outside master |

## Verification
Two cases can land on the same clock edge, and both are provoked on purpose. In the first, a prefix pulse arrives together with a request at an idle boundary, where the request would otherwise win. The bench expects lock_n to drop with grant still low. It then expects the held request to be granted at the edge that ends the lock. In the second, the end-of-lock pulse and the idle boundary fall on one edge while a request is held. The bench expects lock_n to rise and grant to rise together after that single edge.

// File: rtl/buslk_pkg.sv
// Package: shared types for the bus lock arbiter.
// Assumes: all control pulses are synchronous, one clock wide.
package buslk_pkg;

    // Bundle of the one-clock control pulses seen by the submodules
    typedef struct packed {
        logic prefix;    // lock prefix decoded
        logic last_done; // last bus cycle of the locked instruction ended
        logic idle;      // bus-cycle boundary
        logic req;       // outside request pulse
        logic rel;       // outside release pulse
    } ctl_pulses_t;

endpackage

// File: rtl/lock_ctrl.sv
// Module: lock_ctrl
// Holds the lock flag. It sets one clock after a prefix pulse and clears
// after the edge that sees the end-of-instruction pulse.
// Assumes: a prefix pulse is ignored while a grant is outstanding.
module lock_ctrl
    import buslk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ctl_pulses_t pulses,
    input  logic        grant_busy,
    output logic        locked
);

    logic lock_d;

    // Next lock state: start on prefix when free, end on last-cycle pulse
    always_comb begin
        lock_d = locked;
        if (locked) begin
            if (pulses.last_done) lock_d = 1'b0;
        end else if (pulses.prefix && !grant_busy) begin
            lock_d = 1'b1;
        end
    end

    // Lock register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) locked <= 1'b0;
        else        locked <= lock_d;
    end

    p_lock_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && pulses.prefix && !grant_busy) |=> locked);
    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !pulses.last_done) |=> locked);
    p_lock_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && pulses.last_done) |=> !locked);
    p_no_lock_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && grant_busy) |=> !locked);

endmodule

// File: rtl/req_track.sv
// Module: req_track
// Keeps a single held request. It captures a request pulse unless a grant
// is already outstanding, and clears it when the grant logic takes it.
// Assumes: only one request/grant channel.
module req_track
    import buslk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ctl_pulses_t pulses,
    input  logic        grant_busy,
    input  logic        take,
    output logic        want
);

    logic pend_q;
    logic pend_d;

    // A request is wanted if it is held or arriving now with no grant out
    assign want = pend_q | (pulses.req & ~grant_busy);

    // Next held state: clear on take, capture a fresh request otherwise
    always_comb begin
        pend_d = pend_q;
        if (take)                               pend_d = 1'b0;
        else if (pulses.req && !grant_busy)     pend_d = 1'b1;
    end

    // Held request register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    p_pend_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !take) |=> pend_q);
    p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !pend_q);

endmodule

// File: rtl/grant_ctrl.sv
// Module: grant_ctrl
// Issues a grant at an idle boundary when the lock is free or ending, and
// holds it until release. A prefix pulse on the same edge wins over a grant.
// Assumes: the outside master releases with a one-clock pulse.
module grant_ctrl
    import buslk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ctl_pulses_t pulses,
    input  logic        locked,
    input  logic        want,
    output logic        take,
    output logic        grant_q
);

    logic lock_free;

    // Lock is free if clear now or ending at this edge
    assign lock_free = ~locked | pulses.last_done;

    // Hand over only at an idle boundary with no competing prefix
    assign take = want & pulses.idle & lock_free & ~pulses.prefix & ~grant_q;

    // Grant register: set on take, clear on release
    always_ff @(posedge clk) begin
        if (!rst_n)          grant_q <= 1'b0;
        else if (take)       grant_q <= 1'b1;
        else if (pulses.rel) grant_q <= 1'b0;
    end

    p_no_grant_in_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && grant_q));
    p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q && !pulses.rel) |=> grant_q);
    p_grant_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q && pulses.rel) |=> !grant_q);
    p_prefix_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_q && pulses.prefix) |=> !grant_q);

endmodule

// File: rtl/bus_lock_arbiter.sv
// Module: bus_lock_arbiter (top)
// Drives an active-low bus lock for prefixed instructions and one
// request/grant channel whose requests wait out an active lock.
// Assumes: all inputs synchronous to clk; pulses are one clock wide.
module bus_lock_arbiter
    import buslk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_prefix,
    input  logic last_cycle_done,
    input  logic bus_idle,
    input  logic rq_req,
    input  logic rq_release,
    output logic lock_n,
    output logic grant
);

    ctl_pulses_t pulses;
    logic        locked;
    logic        want;
    logic        take;
    logic        grant_q;

    // Gather the input pulses into one bundle
    always_comb begin
        pulses.prefix    = lock_prefix;
        pulses.last_done = last_cycle_done;
        pulses.idle      = bus_idle;
        pulses.req       = rq_req;
        pulses.rel       = rq_release;
    end

    lock_ctrl u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulses     (pulses),
        .grant_busy (grant_q),
        .locked     (locked)
    );

    req_track u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulses     (pulses),
        .grant_busy (grant_q),
        .take       (take),
        .want       (want)
    );

    grant_ctrl u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulses  (pulses),
        .locked  (locked),
        .want    (want),
        .take    (take),
        .grant_q (grant_q)
    );

    assign lock_n = ~locked;
    assign grant  = grant_q;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (lock_n && !grant));
    p_stray_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_n && !lock_prefix && last_cycle_done) |=> lock_n);

endmodule

// File: tb/tb_bus_lock_arbiter.sv
module tb_bus_lock_arbiter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_prefix = 1'b0, last_cycle_done = 1'b0, bus_idle = 1'b0;
    logic rq_req = 1'b0, rq_release = 1'b0;
    logic lock_n, grant;
    int   n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    bus_lock_arbiter dut (
        .clk(clk), .rst_n(rst_n), .lock_prefix(lock_prefix),
        .last_cycle_done(last_cycle_done), .bus_idle(bus_idle),
        .rq_req(rq_req), .rq_release(rq_release),
        .lock_n(lock_n), .grant(grant)
    );

    // Drive pulses for one edge, then clear them; sampling is 1 ns after edge
    task automatic tick(input logic pf, input logic ld, input logic id,
                        input logic rq, input logic rl);
        lock_prefix = pf; last_cycle_done = ld; bus_idle = id;
        rq_req = rq; rq_release = rl;
        @(posedge clk); #1;
        lock_prefix = 0; last_cycle_done = 0; bus_idle = 0;
        rq_req = 0; rq_release = 0;
    endtask

    task automatic chk(input string req, input logic exp_lk, input logic exp_gr);
        n_chk++;
        if (lock_n !== exp_lk || grant !== exp_gr) begin
            n_fail++;
            $display("FAIL %s: lock_n=%b grant=%b expected lock_n=%b grant=%b",
                     req, lock_n, grant, exp_lk, exp_gr);
        end
    endtask

    task automatic t_reset;
        rst_n = 0; tick(0,0,0,0,0); tick(0,0,0,0,0); rst_n = 1;
        chk("R1 reset", 1, 0);
        tick(0,0,1,0,0); chk("R1 idle no grant", 1, 0);
    endtask

    task automatic t_lock;
        tick(1,0,0,0,0); chk("R2 lock start", 0, 0);
        tick(0,0,1,0,0); tick(0,0,0,0,0); chk("R3 lock hold", 0, 0);
        tick(0,1,0,0,0); chk("R3 lock end", 1, 0);
    endtask

    task automatic t_unlocked_req;
        tick(0,0,0,1,0); chk("R6 wait boundary", 1, 0);
        tick(0,0,1,0,0); chk("R6 grant at boundary", 1, 1);
        tick(0,0,1,0,0); tick(0,0,0,0,0); chk("R7 grant hold", 1, 1);
        tick(0,0,0,0,1); chk("R7 release", 1, 0);
        tick(0,0,1,1,0); chk("R6 same-edge grant", 1, 1);
        tick(0,0,0,0,1); chk("R7 release 2", 1, 0);
    endtask

    task automatic t_deferred;
        tick(1,0,0,0,0);
        tick(0,0,1,1,0); chk("R4 held in lock", 0, 0);
        tick(0,0,1,0,0); chk("R4 still held", 0, 0);
        tick(0,1,0,0,0); chk("R5 lock off no boundary", 1, 0);
        tick(0,0,1,0,0); chk("R5 deferred grant", 1, 1);
        tick(0,0,0,0,1);
        tick(1,0,0,0,0); tick(0,0,0,1,0);
        tick(0,1,1,0,0); chk("R5 grant at lock end edge", 1, 1);
        tick(0,0,0,0,1); chk("R7 release 3", 1, 0);
    endtask

    task automatic t_grant_blocks;
        tick(0,0,1,1,0); chk("R6 grant", 1, 1);
        tick(1,0,0,0,0); chk("R8 prefix ignored", 1, 1);
        tick(0,0,0,1,0);
        tick(0,0,0,0,1); chk("R8 no late lock", 1, 0);
        tick(0,0,1,0,0); chk("R10 no second grant", 1, 0);
    endtask

    task automatic t_collision;
        tick(1,0,1,1,0); chk("R9 prefix wins", 0, 0);
        tick(0,1,1,0,0); chk("R9 held then granted", 1, 1);
        tick(0,0,0,0,1);
        tick(0,1,1,0,0); chk("R11 stray last", 1, 0);
    endtask

    task automatic t_reset_mid;
        tick(1,0,0,0,0); tick(0,0,0,1,0);
        rst_n = 0; tick(0,0,0,0,0); rst_n = 1;
        chk("R1 reset clears lock", 1, 0);
        tick(0,0,1,0,0); chk("R1 held request dropped", 1, 0);
    endtask

    initial begin
        fork
            begin
                #1;
                t_reset(); t_lock(); t_unlocked_req(); t_deferred();
                t_grant_blocks(); t_collision(); t_reset_mid();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual=expired expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule